// File: doc/BRIEF.md
# Low-Power-Idle Transmit Sequencer

This block runs the transmit side of the energy-saving idle mode in a 100 Mb/s twisted-pair Ethernet PHY. It takes two inputs: a request to enter low-power idle, and a flag that says frames are waiting. From these it decides what the code-group path sends. The choices are normal IDLE or data, the all-zero SLEEP code (which the downstream scrambler turns into scrambled output), or nothing at all with the line driver switched off.

When the request arrives and no frame is waiting, the block sends SLEEP for a fixed time. It then alternates between a long silent phase and a short refresh burst. The refresh burst reuses the SLEEP code. Each of the three phases has its own timer. A waiting frame, or withdrawal of the request, ends a silent or refresh phase at once. A SLEEP phase always runs to its end. After leaving low-power idle, the block sends plain IDLE for a minimum wake interval. Only then does it raise the ready-for-data flag.

All phase lengths are parameters counted in clock cycles. Each length is checked at elaboration against its legal time window, which is derived from the clock-rate parameter. The scrambler, the 4B/5B encoder and the MLT-3 line coder sit outside this block. This block drives only their select and enable inputs.

Top module: `lpi_tx_sequencer`

## Requirements
- R1: After reset the block is in the normal state: `cg_sel` = 0 (IDLE/data), `tx_en` = 1, `tx_ready` = 1.
- R2: In the normal state, `lpi_req` = 1 with `frame_pend` = 0 moves the block to SLEEP on the next cycle: `cg_sel` = 1 (zero code to scrambler), `tx_en` = 1, `tx_ready` = 0. SLEEP lasts exactly `TS_CYC` cycles.
- R3: When SLEEP ends with `lpi_req` = 1 and `frame_pend` = 0, the block goes silent for exactly `TQ_CYC` cycles: `cg_sel` = 2, `tx_en` = 0, `tx_ready` = 0.
- R4: A silent phase that runs out is followed by a refresh burst of exactly `TR_CYC` cycles (`cg_sel` = 1, `tx_en` = 1, `tx_ready` = 0). A refresh burst that runs out is followed by another silent phase. This cycle repeats for as long as the request stays high.
- R5: `frame_pend` = 1 during a silent or refresh phase ends that phase at the next clock edge, and the block enters WAKE without waiting for the phase timer.
- R6: `lpi_req` = 0 during a silent or refresh phase also enters WAKE at the next clock edge.
- R7: During SLEEP, changes on `frame_pend` or `lpi_req` do not shorten the phase. If either one calls for exit when SLEEP ends, WAKE follows instead of the silent phase.
- R8: WAKE sends `cg_sel` = 0 with `tx_en` = 1 and `tx_ready` = 0 for exactly `TW_CYC` cycles, whatever the inputs do. After that the block is back in the normal state with `tx_ready` = 1.
- R9: In the normal state, `frame_pend` = 1 keeps the block there even when `lpi_req` = 1, because pending frames take priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lpi_req | input | 1 | Request to enter or stay in low-power idle |
| frame_pend | input | 1 | Frames are waiting to be sent |
| cg_sel | output | 2 | Code-group source: 0 IDLE/data, 1 SLEEP (zero code), 2 silent |
| tx_en | output | 1 | Line transmitter enable |
| tx_ready | output | 1 | Data may be sent |

## Verification
The first pattern holds the request high with no frames through two full silent/refresh rounds. This measures each phase length and shows that the phases run in the right order. Frame arrival is then applied in three places: part way through SLEEP, during a silent phase and during a refresh burst. Together these separate a held exit from an early one. Releasing the request in the silent and refresh phases checks the second exit path. Driving both inputs high in the normal state shows that frames take priority, and a request raised during WAKE shows that the wake interval is neither cut short nor skipped.

// File: rtl/lpi_pkg.sv
package lpi_pkg;

    typedef enum logic [2:0] {
        ST_ACTIVE  = 3'd0,
        ST_SLEEP   = 3'd1,
        ST_QUIET   = 3'd2,
        ST_REFRESH = 3'd3,
        ST_WAKE    = 3'd4
    } lpi_st_e;

    typedef enum logic [1:0] {
        CG_IDLE  = 2'd0,
        CG_SLEEP = 2'd1,
        CG_QUIET = 2'd2
    } lpi_cg_e;

    // Timed phases, one timer each
    localparam int NPH        = 4;
    localparam int PH_SLEEP   = 0;
    localparam int PH_QUIET   = 1;
    localparam int PH_REFRESH = 2;
    localparam int PH_WAKE    = 3;

    typedef struct packed {
        lpi_st_e st;
    } seq_s;

    function automatic logic [NPH-1:0] phase_vec(input lpi_st_e s);
        logic [NPH-1:0] v;
        v = '0;
        case (s)
            ST_SLEEP:   v[PH_SLEEP]   = 1'b1;
            ST_QUIET:   v[PH_QUIET]   = 1'b1;
            ST_REFRESH: v[PH_REFRESH] = 1'b1;
            ST_WAKE:    v[PH_WAKE]    = 1'b1;
            default:    v = '0;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/lpi_phase_timer.sv
module lpi_phase_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign done = (cnt_q == '0);

endmodule

// File: rtl/lpi_cg_decode.sv
module lpi_cg_decode
    import lpi_pkg::*;
(
    input  lpi_st_e st,
    output lpi_cg_e sel,
    output logic    tx_en,
    output logic    ready
);

    always_comb begin
        sel   = CG_IDLE;
        tx_en = 1'b1;
        ready = 1'b0;
        unique case (st)
            ST_ACTIVE:  ready = 1'b1;
            ST_SLEEP:   sel = CG_SLEEP;
            ST_QUIET: begin
                sel   = CG_QUIET;
                tx_en = 1'b0;
            end
            ST_REFRESH: sel = CG_SLEEP;
            ST_WAKE:    sel = CG_IDLE;
            default: begin
                sel   = CG_IDLE;
                ready = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/lpi_tx_sequencer.sv
module lpi_tx_sequencer
    import lpi_pkg::*;
#(
    parameter int unsigned CLK_KHZ = 25000,
    parameter int unsigned TS_CYC  = 5000,
    parameter int unsigned TQ_CYC  = 500000,
    parameter int unsigned TR_CYC  = 5000,
    parameter int unsigned TW_CYC  = 625
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       lpi_req,
    input  logic       frame_pend,
    output logic [1:0] cg_sel,
    output logic       tx_en,
    output logic       tx_ready
);

    // Legal windows in cycles (microsecond bounds scaled by clock rate)
    localparam int unsigned TS_MIN = (200 * CLK_KHZ + 999) / 1000;
    localparam int unsigned TS_MAX = (220 * CLK_KHZ) / 1000;
    localparam int unsigned TQ_MIN = (20000 * CLK_KHZ + 999) / 1000;
    localparam int unsigned TQ_MAX = (22000 * CLK_KHZ) / 1000;
    localparam int unsigned TR_MIN = TS_MIN;
    localparam int unsigned TR_MAX = TS_MAX;
    localparam int unsigned TW_MIN = (25 * CLK_KHZ + 999) / 1000;

    localparam int unsigned M01     = (TS_CYC > TQ_CYC) ? TS_CYC : TQ_CYC;
    localparam int unsigned M23     = (TR_CYC > TW_CYC) ? TR_CYC : TW_CYC;
    localparam int unsigned LEN_MAX = (M01 > M23) ? M01 : M23;
    localparam int          CNT_W   = (LEN_MAX > 2) ? $clog2(LEN_MAX) : 1;

    localparam int unsigned PH_LEN [NPH] = '{TS_CYC, TQ_CYC, TR_CYC, TW_CYC};

    if (TS_CYC < TS_MIN || TS_CYC > TS_MAX || TS_CYC == 0) begin : g_bad_ts
        $error("sleep length outside its legal window");
    end
    if (TQ_CYC < TQ_MIN || TQ_CYC > TQ_MAX || TQ_CYC == 0) begin : g_bad_tq
        $error("silent length outside its legal window");
    end
    if (TR_CYC < TR_MIN || TR_CYC > TR_MAX || TR_CYC == 0) begin : g_bad_tr
        $error("refresh length outside its legal window");
    end
    if (TW_CYC < TW_MIN || TW_CYC == 0) begin : g_bad_tw
        $error("wake length below its minimum");
    end

    seq_s           seq_d, seq_q;
    logic [NPH-1:0] ph_done;
    logic [NPH-1:0] ph_cur, ph_nxt, ph_load;
    logic           leave_lpi;

    assign leave_lpi = frame_pend || !lpi_req;

    always_comb begin
        seq_d = seq_q;
        unique case (seq_q.st)
            ST_ACTIVE: begin
                if (lpi_req && !frame_pend) seq_d.st = ST_SLEEP;
            end
            ST_SLEEP: begin
                // sleep always completes; the exit decision is taken at its end
                if (ph_done[PH_SLEEP]) seq_d.st = leave_lpi ? ST_WAKE : ST_QUIET;
            end
            ST_QUIET: begin
                if (leave_lpi)               seq_d.st = ST_WAKE;
                else if (ph_done[PH_QUIET])  seq_d.st = ST_REFRESH;
            end
            ST_REFRESH: begin
                if (leave_lpi)                 seq_d.st = ST_WAKE;
                else if (ph_done[PH_REFRESH])  seq_d.st = ST_QUIET;
            end
            ST_WAKE: begin
                if (ph_done[PH_WAKE]) seq_d.st = ST_ACTIVE;
            end
            default: seq_d.st = ST_ACTIVE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q.st <= ST_ACTIVE;
        end else begin
            seq_q <= seq_d;
        end
    end

    // A phase timer is loaded on the edge that enters its phase
    assign ph_cur  = phase_vec(seq_q.st);
    assign ph_nxt  = phase_vec(seq_d.st);
    assign ph_load = ph_nxt & ~ph_cur;

    for (genvar i = 0; i < NPH; i++) begin : g_tmr
        lpi_phase_timer #(
            .CNT_W (CNT_W)
        ) u_tmr (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (ph_load[i]),
            .load_val (CNT_W'(PH_LEN[i] - 1)),
            .done     (ph_done[i])
        );
    end

    lpi_cg_e sel_w;

    lpi_cg_decode u_dec (
        .st    (seq_q.st),
        .sel   (sel_w),
        .tx_en (tx_en),
        .ready (tx_ready)
    );

    assign cg_sel = sel_w;

endmodule

// File: rtl/lpi_tx_sequencer_chk.sv
module lpi_tx_sequencer_chk #(
    parameter int unsigned TW_CYC = 625
) (
    input logic       clk,
    input logic       rst_n,
    input logic       lpi_req,
    input logic       frame_pend,
    input logic [1:0] cg_sel,
    input logic       tx_en,
    input logic       tx_ready
);

    logic [31:0] wake_cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wake_cnt_q <= '0;
        end else if (!tx_ready && tx_en && cg_sel == 2'd0) begin
            wake_cnt_q <= wake_cnt_q + 1;
        end else begin
            wake_cnt_q <= '0;
        end
    end

    // R2: request with no frames leaves the normal state for SLEEP
    a_r2_enter_sleep: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_ready && lpi_req && !frame_pend) |=> (cg_sel == 2'd1 && !tx_ready));

    // R9: pending frames hold the normal state
    a_r9_frames_first: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_ready && frame_pend) |=> tx_ready);

    // R5: frames end a silent phase at once
    a_r5_quiet_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_en && frame_pend) |=> (tx_en && cg_sel == 2'd0 && !tx_ready));

    // R6: request withdrawal ends a silent phase at once
    a_r6_release_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_en && !lpi_req) |=> (tx_en && cg_sel == 2'd0));

    // R3: the line driver switches off only after zero-code transmission
    a_r3_off_after_sleep: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_en) |-> ($past(cg_sel) == 2'd1));

    // R8: ready returns only after exactly the wake interval of IDLE
    a_r8_wake_len: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_ready) |-> (wake_cnt_q == TW_CYC));

endmodule

bind lpi_tx_sequencer lpi_tx_sequencer_chk #(
    .TW_CYC (TW_CYC)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .lpi_req    (lpi_req),
    .frame_pend (frame_pend),
    .cg_sel     (cg_sel),
    .tx_en      (tx_en),
    .tx_ready   (tx_ready)
);

// File: tb/sim_lpi_tx_sequencer.sv
module sim_lpi_tx_sequencer;

    localparam int CLK_PERIOD = 10;
    localparam int KHZ = 100;
    localparam int TS  = 21;
    localparam int TQ  = 2000;
    localparam int TR  = 20;
    localparam int TW  = 4;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       lpi_req;
    logic       frame_pend;
    logic [1:0] cg_sel;
    logic       tx_en;
    logic       tx_ready;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    lpi_tx_sequencer #(
        .CLK_KHZ (KHZ),
        .TS_CYC  (TS),
        .TQ_CYC  (TQ),
        .TR_CYC  (TR),
        .TW_CYC  (TW)
    ) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .lpi_req    (lpi_req),
        .frame_pend (frame_pend),
        .cg_sel     (cg_sel),
        .tx_en      (tx_en),
        .tx_ready   (tx_ready)
    );

    typedef struct {
        logic [1:0] sel;
        logic       en;
        logic       rdy;
        string      tag;
    } exp_t;

    exp_t sb_q[$];

    // Output triples: normal, sleep, silent, refresh, wake
    localparam logic [3:0] O_ACT = 4'b0011;
    localparam logic [3:0] O_SLP = 4'b0110;
    localparam logic [3:0] O_QUI = 4'b1000;
    localparam logic [3:0] O_REF = 4'b0110;
    localparam logic [3:0] O_WAK = 4'b0010;

    task automatic step(input logic l, input logic f, input logic [3:0] o, input string t);
        exp_t item;
        @(negedge clk);
        lpi_req    = l;
        frame_pend = f;
        item.sel = o[3:2];
        item.en  = o[1];
        item.rdy = o[0];
        item.tag = t;
        sb_q.push_back(item);
    endtask

    task automatic seg(input logic l, input logic f, input int n, input logic [3:0] o,
                       input string t);
        for (int k = 0; k < n; k++) step(l, f, o, t);
    endtask

    // Monitor: one expected item per clock, sampled after the edge
    initial begin
        exp_t e;
        forever begin
            @(posedge clk);
            #2;
            if (sb_q.size() > 0) begin
                e = sb_q.pop_front();
                n_chk++;
                if ({cg_sel, tx_en, tx_ready} !== {e.sel, e.en, e.rdy}) begin
                    n_fail++;
                    $display("FAIL %s: got sel=%0d en=%b rdy=%b, expected sel=%0d en=%b rdy=%b",
                             e.tag, cg_sel, tx_en, tx_ready, e.sel, e.en, e.rdy);
                end
            end
        end
    end

    initial begin
        repeat (120000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got no completion, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        lpi_req = 1'b0;
        frame_pend = 1'b0;
        repeat (3) @(negedge clk);
        // R1: reset state
        n_chk++;
        if ({cg_sel, tx_en, tx_ready} !== O_ACT) begin
            n_fail++;
            $display("FAIL R1: got %b, expected %b", {cg_sel, tx_en, tx_ready}, O_ACT);
        end
        rst_n = 1'b1;
        seg(0, 0, 3, O_ACT, "R1");

        // R9: both inputs high keeps the normal state
        seg(1, 1, 5, O_ACT, "R9");

        // R2, R3, R4: undisturbed low-power idle through two rounds
        seg(1, 0, TS, O_SLP, "R2");
        seg(1, 0, TQ, O_QUI, "R3");
        seg(1, 0, TR, O_REF, "R4");
        seg(1, 0, TQ, O_QUI, "R4");
        seg(1, 0, 3, O_REF, "R4");
        // R5: frame in refresh exits early; R8 wake ignores inputs
        step(1, 1, O_WAK, "R5");
        seg(1, 1, TW - 1, O_WAK, "R8");
        seg(1, 1, 3, O_ACT, "R8");

        // R5: frame in silent phase
        seg(1, 0, TS, O_SLP, "R2");
        seg(1, 0, 10, O_QUI, "R3");
        step(1, 1, O_WAK, "R5");
        seg(1, 0, TW - 1, O_WAK, "R8");
        step(0, 0, O_ACT, "R8");
        seg(0, 0, 2, O_ACT, "R8");

        // R7: frame and release during sleep do not shorten it
        seg(1, 0, 5, O_SLP, "R2");
        seg(0, 1, TS - 5, O_SLP, "R7");
        seg(0, 0, TW, O_WAK, "R7");
        seg(0, 0, 2, O_ACT, "R7");

        // R6: release in silent phase
        seg(1, 0, TS, O_SLP, "R2");
        seg(1, 0, 7, O_QUI, "R3");
        seg(0, 0, TW, O_WAK, "R6");
        seg(0, 0, 2, O_ACT, "R6");

        // R6: release in refresh
        seg(1, 0, TS, O_SLP, "R2");
        seg(1, 0, TQ, O_QUI, "R3");
        seg(1, 0, 5, O_REF, "R4");
        seg(0, 0, TW, O_WAK, "R6");
        seg(0, 0, 2, O_ACT, "R6");

        @(posedge clk);
        #3;
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule